// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns one floating-point short-vector request into a stream of register index triples. The register file is split into circular banks of 8 single-precision or 4 double-precision registers. A one-cycle start pulse presents the precision flag, the destination (d) and operand (n, m) register fields, the programmed length and the stride. The block then emits one (d, n, m) triple per clock with `valid_o` high, and raises `done_o` for a single cycle after the last triple.

Each index advances by the stride inside its own bank and wraps around to the bank base. The banks that hold the lowest registers (and, for doubles, the first bank of the upper half) are scalar banks. A destination in a scalar bank cuts the operation to one element. An m operand in a scalar bank stays fixed while d and n advance. Illegal length and stride combinations produce a one-cycle `unpred_o` pulse and no triples.

Top module: `svec_index_seq`

## Requirements
- R1: After reset `valid_o`, `done_o` and `unpred_o` are low.
- R2: Index encoding. In single precision the index is base*2 + extra bit. In double precision it is base + 16 when the extra bit is set, otherwise base. Indices are 5 bits wide.
- R3: After each element every index keeps its bank base. The in-bank part becomes (part + stride) mod bank size, where the bank size is 8 for singles and 4 for doubles.
- R4: A legal start accepted at clock edge k drives the first triple with `valid_o` high after edge k. One triple follows per clock, as many as the effective length. `done_o` is high for exactly the one cycle after the last triple.
- R5: A destination in a scalar bank gives an effective length of 1, whatever the programmed length. The scalar banks are single indices 0-7 and double indices 0-3 and 16-19.
- R6: An m operand in a scalar bank keeps the same index on every element while d and n advance.
- R7: If stride times length exceeds the bank size, `unpred_o` is high for one cycle after the start edge. No triple is emitted and no `done_o` follows.
- R8: Length 1 with a stride other than 1 is unpredictable, as in R7. Length 1 with stride 1 emits exactly one triple.
- R9: The stride input is the stride value itself: 1 and 2 are legal, and 0 and 3 are unpredictable. A length of 0 is also unpredictable.
- R10: A start pulse that arrives while `valid_o` is high is ignored. The running sequence continues unchanged, and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| d_base_i | input | 4 | Destination base field |
| d_ext_i | input | 1 | Destination extra bit |
| n_base_i | input | 4 | First operand base field |
| n_ext_i | input | 1 | First operand extra bit |
| m_base_i | input | 4 | Second operand base field |
| m_ext_i | input | 1 | Second operand extra bit |
| len_i | input | 4 | Programmed vector length |
| stride_i | input | 2 | Vector stride (1 or 2) |
| valid_o | output | 1 | Triple valid strobe |
| idx_d_o | output | 5 | Destination register index |
| idx_n_o | output | 5 | First operand register index |
| idx_m_o | output | 5 | Second operand register index |
| done_o | output | 1 | One-cycle pulse after the last triple |
| unpred_o | output | 1 | One-cycle pulse for an illegal request |

## Verification
A corrupted remaining-element counter shows as `done_o` arriving early or late, visible in the first cycle after the expected last triple. A wrong bank base or a wrong wrap width shows on the very next triple as an index that leaves its bank or wraps to the wrong place, so sequences are chosen to cross the top of a bank. A lost scalar flag on m shows on the second element as a moving m index. A wrong legality decision shows one cycle after the start as a missing or spurious `unpred_o` pulse.

// File: rtl/svec_pkg.sv
package svec_pkg;
    localparam int BASE_W  = 4;
    localparam int IDX_W   = BASE_W + 1;
    localparam int LEN_W   = 4;
    localparam int STR_W   = 2;
    localparam int SGL_LOG = 3;   // 8 singles per bank
    localparam int DBL_LOG = 2;   // 4 doubles per bank

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             unpred;
        logic             dbl;
        logic [STR_W-1:0] stride;
        logic             m_fix;
        logic [LEN_W-1:0] left;
        idx_t             d;
        idx_t             n;
        idx_t             m;
    } seq_t;

    function automatic logic same_bank(idx_t a, idx_t b, logic dbl);
        if (dbl) return a[IDX_W-1:DBL_LOG] == b[IDX_W-1:DBL_LOG];
        return a[IDX_W-1:SGL_LOG] == b[IDX_W-1:SGL_LOG];
    endfunction
endpackage

// File: rtl/svec_encode.sv
module svec_encode
    import svec_pkg::*;
(
    input  logic [BASE_W-1:0] base_i,
    input  logic              ext_i,
    input  logic              dbl_i,
    output idx_t              idx_o,
    output logic              scalar_o
);
    always_comb begin
        // double: extra bit selects the upper half; single: extra bit is the LSB
        idx_o = dbl_i ? {ext_i, base_i} : {base_i, ext_i};
        if (dbl_i) scalar_o = (idx_o[IDX_W-2:DBL_LOG] == '0);
        else       scalar_o = (idx_o[IDX_W-1:SGL_LOG] == '0);
    end
endmodule

// File: rtl/svec_bank_step.sv
module svec_bank_step
    import svec_pkg::*;
(
    input  idx_t             cur_i,
    input  logic             dbl_i,
    input  logic [STR_W-1:0] stride_i,
    output idx_t             nxt_o
);
    logic [SGL_LOG-1:0] s_lo;
    logic [DBL_LOG-1:0] d_lo;

    always_comb begin
        s_lo  = cur_i[SGL_LOG-1:0] + SGL_LOG'(stride_i);
        d_lo  = cur_i[DBL_LOG-1:0] + DBL_LOG'(stride_i);
        nxt_o = dbl_i ? {cur_i[IDX_W-1:DBL_LOG], d_lo}
                      : {cur_i[IDX_W-1:SGL_LOG], s_lo};
    end
endmodule

// File: rtl/svec_legal.sv
module svec_legal
    import svec_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    input  logic [STR_W-1:0] stride_i,
    input  logic             dbl_i,
    output logic             illegal_o
);
    localparam int PW = LEN_W + STR_W;
    logic [PW-1:0] span;
    logic [PW-1:0] bank;
    logic          bad_str;

    always_comb begin
        span      = PW'(len_i) * PW'(stride_i);
        bank      = dbl_i ? PW'(1 << DBL_LOG) : PW'(1 << SGL_LOG);
        bad_str   = !(stride_i == STR_W'(1) || stride_i == STR_W'(2));
        illegal_o = bad_str
                 || (len_i == '0)
                 || (span > bank)
                 || ((len_i == LEN_W'(1)) && (stride_i != STR_W'(1)));
    end
endmodule

// File: rtl/svec_index_seq.sv
module svec_index_seq
    import svec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dbl_i,
    input  logic [BASE_W-1:0] d_base_i,
    input  logic              d_ext_i,
    input  logic [BASE_W-1:0] n_base_i,
    input  logic              n_ext_i,
    input  logic [BASE_W-1:0] m_base_i,
    input  logic              m_ext_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [STR_W-1:0]  stride_i,
    output logic              valid_o,
    output idx_t              idx_d_o,
    output idx_t              idx_n_o,
    output idx_t              idx_m_o,
    output logic              done_o,
    output logic              unpred_o
);
    localparam int NOPS = 3;   // 0 = d, 1 = n, 2 = m

    seq_t st_d, st_q;

    logic [BASE_W-1:0] base_a [NOPS];
    logic              ext_a  [NOPS];
    idx_t              enc_a  [NOPS];
    logic              scl_a  [NOPS];
    idx_t              cur_a  [NOPS];
    idx_t              nxt_a  [NOPS];
    logic              illegal;

    always_comb begin
        base_a[0] = d_base_i; ext_a[0] = d_ext_i; cur_a[0] = st_q.d;
        base_a[1] = n_base_i; ext_a[1] = n_ext_i; cur_a[1] = st_q.n;
        base_a[2] = m_base_i; ext_a[2] = m_ext_i; cur_a[2] = st_q.m;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        svec_encode u_enc (
            .base_i   (base_a[g]),
            .ext_i    (ext_a[g]),
            .dbl_i    (dbl_i),
            .idx_o    (enc_a[g]),
            .scalar_o (scl_a[g])
        );
        svec_bank_step u_step (
            .cur_i    (cur_a[g]),
            .dbl_i    (st_q.dbl),
            .stride_i (st_q.stride),
            .nxt_o    (nxt_a[g])
        );
    end

    svec_legal u_legal (
        .len_i     (len_i),
        .stride_i  (stride_i),
        .dbl_i     (dbl_i),
        .illegal_o (illegal)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.unpred = 1'b0;
        if (st_q.valid) begin
            if (st_q.left == '0) begin
                st_d.valid = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.left = st_q.left - LEN_W'(1);
                st_d.d    = nxt_a[0];
                st_d.n    = nxt_a[1];
                if (!st_q.m_fix) st_d.m = nxt_a[2];
            end
        end else if (start_i) begin
            if (illegal) begin
                st_d.unpred = 1'b1;
            end else begin
                st_d.valid  = 1'b1;
                st_d.dbl    = dbl_i;
                st_d.stride = stride_i;
                st_d.m_fix  = scl_a[2];
                st_d.left   = scl_a[0] ? '0 : len_i - LEN_W'(1);
                st_d.d      = enc_a[0];
                st_d.n      = enc_a[1];
                st_d.m      = enc_a[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.valid;
    assign done_o   = st_q.done;
    assign unpred_o = st_q.unpred;
    assign idx_d_o  = st_q.d;
    assign idx_n_o  = st_q.n;
    assign idx_m_o  = st_q.m;

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(valid_o) && !valid_o));
    // R7
    unpred_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> (!valid_o && !done_o && !$past(valid_o)));
    // R6
    m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && $past(st_q.m_fix)) |-> $stable(idx_m_o));
    // R3
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |->
            (same_bank(idx_d_o, $past(idx_d_o), st_q.dbl)
          && same_bank(idx_n_o, $past(idx_n_o), st_q.dbl)));
endmodule

// File: tb/svec_index_seq_tb.sv
`timescale 1ns/1ps
module svec_index_seq_tb;
    typedef struct packed {
        logic       dbl;
        logic [3:0] db; logic dx;
        logic [3:0] nb; logic nx;
        logic [3:0] mb; logic mx;
        logic [3:0] len;
        logic [1:0] str;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd4, 2'd1}, // single, no wrap
        '{1'b0, 4'd7,  1'b0, 4'd11, 1'b0, 4'd15, 1'b0, 4'd4, 2'd2}, // single, wrap by 2
        '{1'b0, 4'd4,  1'b1, 4'd8,  1'b1, 4'd1,  1'b1, 4'd3, 2'd1}, // m scalar
        '{1'b0, 4'd1,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd4, 2'd1}, // d scalar
        '{1'b1, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd4, 2'd1}, // double full bank
        '{1'b1, 4'd6,  1'b0, 4'd10, 1'b0, 4'd14, 1'b0, 4'd2, 2'd2}, // double wrap
        '{1'b1, 4'd4,  1'b1, 4'd8,  1'b1, 4'd1,  1'b0, 4'd3, 2'd1}, // double, m scalar
        '{1'b1, 4'd1,  1'b1, 4'd8,  1'b0, 4'd12, 1'b0, 4'd3, 2'd1}, // d scalar upper half
        '{1'b0, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd5, 2'd2}, // 10 > 8
        '{1'b1, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd3, 2'd2}, // 6 > 4
        '{1'b0, 4'd5,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd1, 2'd2}, // len 1 stride 2
        '{1'b0, 4'd5,  1'b0, 4'd9,  1'b1, 4'd13, 1'b0, 4'd1, 2'd1}, // len 1 stride 1
        '{1'b0, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd2, 2'd0}, // stride 0
        '{1'b0, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd2, 2'd3}, // stride 3
        '{1'b0, 4'd4,  1'b0, 4'd8,  1'b0, 4'd12, 1'b0, 4'd0, 2'd1}, // len 0
        '{1'b0, 4'd7,  1'b1, 4'd9,  1'b0, 4'd13, 1'b1, 4'd8, 2'd1}  // full single bank
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dbl = 1'b0;
    logic [3:0] db = '0, nb = '0, mb = '0, len = '0;
    logic dx = 1'b0, nx = 1'b0, mx = 1'b0;
    logic [1:0] str = '0;
    logic valid, done, unpred;
    logic [4:0] id, in, im;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    svec_index_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dbl_i(dbl),
        .d_base_i(db), .d_ext_i(dx), .n_base_i(nb), .n_ext_i(nx),
        .m_base_i(mb), .m_ext_i(mx), .len_i(len), .stride_i(str),
        .valid_o(valid), .idx_d_o(id), .idx_n_o(in), .idx_m_o(im),
        .done_o(done), .unpred_o(unpred)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 encoding
    function automatic int enc(logic d, logic [3:0] b, logic x);
        return d ? (int'(b) + (x ? 16 : 0)) : (int'(b) * 2 + int'(x));
    endfunction
    // R5 scalar bank membership
    function automatic bit is_scl(logic d, int i);
        return d ? (i < 4 || (i >= 16 && i < 20)) : (i < 8);
    endfunction
    // R3 in-bank advance
    function automatic int adv(logic d, int i, int s);
        int bs = d ? 4 : 8;
        return (i - (i % bs)) + ((i % bs) + s) % bs;
    endfunction
    // R7 R8 R9 legality
    function automatic bit bad(logic d, int l, int s);
        int bs = d ? 4 : 8;
        return (s != 1 && s != 2) || l == 0 || l * s > bs || (l == 1 && s != 1);
    endfunction

    task automatic drive(input vec_t v);
        @(negedge clk);
        dbl = v.dbl; db = v.db; dx = v.dx; nb = v.nb; nx = v.nx;
        mb = v.mb; mx = v.mx; len = v.len; str = v.str; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int ed, en, em, el;
        bit mfix;
        drive(v);
        ed = enc(v.dbl, v.db, v.dx);
        en = enc(v.dbl, v.nb, v.nx);
        em = enc(v.dbl, v.mb, v.mx);
        mfix = is_scl(v.dbl, em);
        if (bad(v.dbl, int'(v.len), int'(v.str))) begin
            chk(unpred, 1, "R7 R8 R9 unpred pulse");
            chk(valid, 0, "R7 no triple");
            @(negedge clk);
            chk(unpred, 0, "R7 unpred one cycle");
            chk(valid, 0, "R7 no triple later");
            chk(done, 0, "R7 no done");
        end else begin
            el = is_scl(v.dbl, ed) ? 1 : int'(v.len);
            chk(unpred, 0, "R8 legal no unpred");
            for (int i = 0; i < el; i++) begin
                chk(valid, 1, "R4 valid per element");
                chk(int'(id), ed, "R2 R3 d index");
                chk(int'(in), en, "R2 R3 n index");
                chk(int'(im), em, "R6 m index");
                ed = adv(v.dbl, ed, int'(v.str));
                en = adv(v.dbl, en, int'(v.str));
                if (!mfix) em = adv(v.dbl, em, int'(v.str));
                @(negedge clk);
            end
            chk(valid, 0, "R4 R5 length");
            chk(done, 1, "R4 done after last");
            @(negedge clk);
            chk(done, 0, "R4 done one cycle");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(valid, 0, "R1 valid");
        chk(done, 0, "R1 done");
        chk(unpred, 0, "R1 unpred");
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid, 0, "R1 idle after release");

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10 start during a running sequence is ignored
        drive('{1'b0, 4'd4, 1'b0, 4'd8, 1'b0, 4'd12, 1'b0, 4'd4, 2'd1});
        chk(int'(id), 8, "R10 first d");
        dbl = 1'b1; db = 4'd6; nb = 4'd2; mb = 4'd3; len = 4'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(int'(id), 9, "R10 d continues");
        chk(int'(in), 17, "R10 n continues");
        @(negedge clk);
        chk(int'(id), 10, "R10 d third");
        @(negedge clk);
        chk(int'(id), 11, "R10 d fourth");
        @(negedge clk);
        chk(done, 1, "R10 done");
        chk(valid, 0, "R10 no extra");
        @(negedge clk);
        chk(valid, 0, "R10 no second sequence");
        @(negedge clk);
        chk(valid, 0, "R10 still idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule